// File: doc/BRIEF.md
# Interrupt Status Register with Bus-Error Capture

This block keeps the interrupt status word of a bus-master network controller. The DMA engines and the bus-master interface send it one-cycle event pulses. Each pulse sets a sticky status bit. A separate mask register selects which of the interrupt-capable bits may drive the host interrupt. The interrupt line is a registered level. The host clears status bits by writing ones to them.

When the bus master reports a failed transaction, the block sets the bus-error bit. At the same moment it stores a 3-bit code that gives the cause of the failure. The block also holds the base address of the transmit descriptor list. The host can change that address only while the transmit DMA reports that it has stopped.

All three registers sit behind one register port. The port has a 2-bit word select, a write strobe and a read path that is combinational. Address 0 selects the status word, address 1 the mask and address 2 the descriptor base. Address 3 is unused.

Top module: `intr_status_reg`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: A high `evt_i[n]` sets status bit n for n in 0..22, except n=13. The bit then stays set until the host clears it.
- R3: A write to address 0 clears each status bit whose `reg_wdata` bit is 1. Bits written with 0 keep their value.
- R4: If a new event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: `irq_o` is high exactly one cycle after a cycle in which some status bit and its mask bit are both 1, among bits 0..8, 10, 11 and 13. Status bits 9, 12 and 14..22 never drive `irq_o`.
- R6: Status bit 13 is set by `berr_mabort` or by `berr_tabort`. `berr_parity` sets it only while `parity_resp_en` is high.
- R7: Bits 25:23 of the status word take an error code when bit 13 goes from 0 to 1. The codes are 000 for parity, 001 for master abort and 010 for target abort. When several causes arrive together, the lowest code wins. While bit 13 stays set, the code does not change, even if a clear of bit 13 and a new error arrive in the same cycle.
- R8: Bits 25:23 read 000 whenever bit 13 is 0. Bits 31:26 of the status word always read 0. Writes do not alter bits 25:23. `evt_i[13]` has no effect.
- R9: The mask register at address 1 stores only bits 0..8, 10, 11 and 13. All its other bits read 0.
- R10: A write to address 2 loads bits 31:2 of the descriptor base only while `txdma_stopped` is high. Bits 1:0 always read 0.
- R11: Address 3 reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Word select: 0 status, 1 mask, 2 descriptor base |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| evt_i | input | 23 | Event pulses for status bits 22..0 |
| berr_parity | input | 1 | Parity error seen by bus master |
| berr_mabort | input | 1 | Transaction ended by master abort |
| berr_tabort | input | 1 | Transaction ended by target abort |
| parity_resp_en | input | 1 | Enables recording of parity errors |
| txdma_stopped | input | 1 | Transmit DMA is in its stopped state |
| irq_o | output | 1 | Level interrupt to host |

## Verification
The assertions take two things for granted about the inputs. The event and error lines are synchronous to `clk`, and the stopped flag is stable when the write strobe samples it. The bench changes every input on the falling edge only, so each value is steady through the rising edge that samples it. The bench applies both directed sequences and a pseudo-random mix, and the mix includes error pulses that arrive while bit 13 is already set and in the same cycle as a clear of that bit.

// File: rtl/intr_status_reg.sv
module intr_status_reg #(
  parameter int EVT_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             berr_parity,
  input  logic             berr_mabort,
  input  logic             berr_tabort,
  input  logic             parity_resp_en,
  input  logic             txdma_stopped,
  output logic             irq_o
);
  localparam int          BERR_BIT = 13;
  localparam logic [31:0] IRQ_SRC  = 32'h0000_2DFF;
  localparam logic [EVT_W-1:0] EVT_OK = ~(EVT_W'(1) << BERR_BIT);

  logic [EVT_W-1:0] st_q, st_d, clr, set;
  logic [2:0]       bet_q, bet_d;
  logic [31:0]      mask_q;
  logic [29:0]      txb_q;
  logic             irq_q;

  wire st_wr  = reg_wr && (reg_addr == 2'd0);
  wire mk_wr  = reg_wr && (reg_addr == 2'd1);
  wire txb_wr = reg_wr && (reg_addr == 2'd2) && txdma_stopped;
  wire par_ok = berr_parity && parity_resp_en;
  wire hit    = par_ok || berr_mabort || berr_tabort;

  assign clr  = st_wr ? reg_wdata[EVT_W-1:0] : '0;
  assign set  = (evt_i & EVT_OK) | (EVT_W'(hit) << BERR_BIT);
  assign st_d = (st_q & ~clr) | set;

  always_comb begin
    bet_d = bet_q;
    if (!st_q[BERR_BIT] && hit)
      bet_d = par_ok ? 3'b000 : (berr_mabort ? 3'b001 : 3'b010);
    else if (!st_d[BERR_BIT])
      bet_d = 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      bet_q  <= '0;
      mask_q <= '0;
      txb_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      bet_q <= bet_d;
      irq_q <= |({{(32-EVT_W){1'b0}}, st_q} & mask_q & IRQ_SRC);
      if (mk_wr)  mask_q <= reg_wdata & IRQ_SRC;
      if (txb_wr) txb_q  <= reg_wdata[31:2];
    end
  end

  always_comb begin
    unique case (reg_addr)
      2'd0:    reg_rdata = {6'b0, bet_q, st_q};
      2'd1:    reg_rdata = mask_q;
      2'd2:    reg_rdata = {txb_q, 2'b00};
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o = irq_q;
endmodule

module intr_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [22:0] st_q,
  input logic [2:0]  bet_q,
  input logic [31:0] mask_q,
  input logic [29:0] txb_q,
  input logic        irq_q,
  input logic [1:0]  reg_addr,
  input logic        reg_wr,
  input logic        txdma_stopped,
  input logic        berr_parity,
  input logic        berr_mabort,
  input logic        berr_tabort,
  input logic        parity_resp_en
);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 2'd0) |=> (($past(st_q) & ~st_q) == '0));

  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(|({9'b0, st_q} & mask_q & 32'h0000_2DFF)));

  p_parity_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_q[13] && berr_parity && !parity_resp_en && !berr_mabort && !berr_tabort)
      |=> !st_q[13]);

  p_type_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[13] && $past(st_q[13])) |-> $stable(bet_q));

  p_type_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q[13] |-> (bet_q == 3'b000));

  p_txb_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !txdma_stopped |=> $stable(txb_q));
endmodule

bind intr_status_reg intr_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st_q(st_q), .bet_q(bet_q), .mask_q(mask_q),
  .txb_q(txb_q), .irq_q(irq_q), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .txdma_stopped(txdma_stopped), .berr_parity(berr_parity),
  .berr_mabort(berr_mabort), .berr_tabort(berr_tabort),
  .parity_resp_en(parity_resp_en)
);

// File: tb/intr_status_reg_tb_top.sv
module intr_status_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [22:0] evt_i = '0;
  logic        berr_parity = 1'b0, berr_mabort = 1'b0, berr_tabort = 1'b0;
  logic        parity_resp_en = 1'b0, txdma_stopped = 1'b0;
  logic        irq_o;

  always #10 clk = ~clk;

  intr_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
    .berr_parity(berr_parity), .berr_mabort(berr_mabort),
    .berr_tabort(berr_tabort), .parity_resp_en(parity_resp_en),
    .txdma_stopped(txdma_stopped), .irq_o(irq_o)
  );

  int nchk = 0, nbad = 0;
  bit [31:0] m_st = 0, m_mk = 0, m_tx = 0;
  int m_bet = 0;
  bit m_irq = 0;
  bit done = 0;
  localparam bit [31:0] IRQ_BITS = 32'h2DFF;

  function automatic bit [31:0] model_read(input bit [1:0] a);
    case (a)
      2'd0: return m_st | (32'(m_bet) << 23);
      2'd1: return m_mk;
      2'd2: return m_tx;
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare(input string tag);
    bit [31:0] exp_rd;
    exp_rd = model_read(reg_addr);
    nchk++;
    if (reg_rdata !== exp_rd) begin
      nbad++;
      $display("FAIL %s rdata addr %0d: got %h exp %h", tag, reg_addr, reg_rdata, exp_rd);
    end
    nchk++;
    if (irq_o !== m_irq) begin
      nbad++;
      $display("FAIL %s irq: got %b exp %b", tag, irq_o, m_irq);
    end
  endtask

  task automatic cyc(input string tag);
    bit hit, par_ok;
    bit [31:0] clrv, nst;
    par_ok = berr_parity && parity_resp_en;
    hit = par_ok || berr_mabort || berr_tabort;
    clrv = (reg_wr && reg_addr == 2'd0) ? reg_wdata : 32'h0;
    nst = m_st & ~clrv;
    for (int i = 0; i < 23; i++)
      if (evt_i[i] && i != 13) nst[i] = 1'b1;
    if (hit) nst[13] = 1'b1;
    if (!m_st[13] && hit) m_bet = par_ok ? 0 : (berr_mabort ? 1 : 2);
    else if (!nst[13]) m_bet = 0;
    m_irq = (m_st & m_mk & IRQ_BITS) != 0;
    if (reg_wr && reg_addr == 2'd1) m_mk = reg_wdata & IRQ_BITS;
    if (reg_wr && reg_addr == 2'd2 && txdma_stopped) m_tx = reg_wdata & ~32'h3;
    m_st = nst & 32'h007F_FFFF;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    reg_wr = 1'b0; evt_i = '0;
    berr_parity = 1'b0; berr_mabort = 1'b0; berr_tabort = 1'b0;
  endtask

  task automatic wr(input bit [1:0] a, input bit [31:0] d, input string tag);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    cyc(tag);
  endtask

  task automatic rd(input bit [1:0] a, input string tag);
    reg_addr = a; reg_wr = 1'b0;
    cyc(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    nchk++; nbad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1; compare("R1");
    end
    rd(2'd0, "R1");

    wr(2'd1, 32'hFFFF_FFFF, "R9");
    rd(2'd1, "R9");

    evt_i = 23'h000008; rd(2'd0, "R2");
    rd(2'd0, "R2");
    rd(2'd0, "R5");

    wr(2'd0, 32'h0, "R3");
    wr(2'd0, 32'h8, "R3");
    rd(2'd0, "R5");

    evt_i = 23'h001200; rd(2'd0, "R5");
    rd(2'd0, "R5");
    rd(2'd0, "R5");
    wr(2'd0, 32'hFFFF_FFFF, "R3");

    evt_i = 23'h20; rd(2'd0, "R4");
    evt_i = 23'h20; wr(2'd0, 32'h20, "R4");
    rd(2'd0, "R4");
    wr(2'd0, 32'h20, "R3");

    berr_parity = 1'b1; parity_resp_en = 1'b0; rd(2'd0, "R6");
    rd(2'd0, "R6");
    parity_resp_en = 1'b1; berr_parity = 1'b1; rd(2'd0, "R6");
    rd(2'd0, "R7");
    wr(2'd0, 32'h2000, "R8");
    rd(2'd0, "R8");

    berr_mabort = 1'b1; berr_tabort = 1'b1; rd(2'd0, "R7");
    berr_tabort = 1'b1; rd(2'd0, "R7");
    berr_tabort = 1'b1; wr(2'd0, 32'h2000, "R7");
    rd(2'd0, "R7");
    wr(2'd0, 32'h2000, "R7");
    berr_tabort = 1'b1; rd(2'd0, "R7");
    wr(2'd0, 32'h0380_0000, "R8");
    wr(2'd0, 32'h2000, "R8");
    evt_i = 23'h2000; rd(2'd0, "R8");
    rd(2'd0, "R8");

    txdma_stopped = 1'b0; wr(2'd2, 32'h1234_5678, "R10");
    rd(2'd2, "R10");
    txdma_stopped = 1'b1; wr(2'd2, 32'hDEAD_BEEF, "R10");
    rd(2'd2, "R10");

    wr(2'd3, 32'hFFFF_FFFF, "R11");
    rd(2'd3, "R11");
    rd(2'd1, "R11");

    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      evt_i = (lfsr[3:0] == 4'h0) ? 23'(lfsr >> 7) : 23'h0;
      berr_parity = lfsr[12] & lfsr[13] & lfsr[14];
      berr_mabort = lfsr[15] & lfsr[16] & lfsr[17];
      berr_tabort = lfsr[18] & lfsr[19] & lfsr[20];
      parity_resp_en = lfsr[21];
      txdma_stopped = lfsr[22];
      reg_addr = lfsr[24:23];
      reg_wr = lfsr[25] & lfsr[26];
      reg_wdata = {lfsr[15:0], lfsr[31:16]};
      cyc("R5");
    end
    finish_run();
  end
endmodule